// File: doc/BRIEF.md
# Monitor alarm and warning comparator

This block checks five 16-bit diagnostic readings of an optical module against limits that software has stored. The readings are module temperature, supply voltage, transmitter bias current, transmitted optical power and received optical power. Each reading has four limits: a high and a low alarm limit and a high and a low warning limit. The result is four flag bytes, laid out in the fixed bit positions that the diagnostic memory map expects. Two of the bytes carry alarms and two carry warnings.

The limits arrive as a flat 40-byte region, in the same byte order as the memory that holds them. The readings arrive as a flat bus of five words. A pulse on the sample strobe starts a new comparison. All twenty flags are then replaced together, one clock later. Between strobes the flag bytes hold their values, whatever the inputs do. Temperature is a two's-complement value in steps of 1/256 degree, so it is compared as a signed number. The other four readings are compared unsigned.

Top module: `mon_limit_cmp`

## Requirements
- R1: From reset until the first sample strobe, all four flag bytes read 0x00, even when the readings lie outside their limits.
- R2: Channel index c is 0 for temperature, 1 for supply, 2 for bias, 3 for transmit power and 4 for receive power. The reading of channel c is `reading_i[16c+15:16c]`. Limit byte b is `limit_bytes_i[8b+7:8b]`. Channel c uses bytes 8c to 8c+7, holding four words in this order: high alarm, low alarm, high warning, low warning. Each word is big-endian: the lower byte address holds bits 15:8.
- R3: Channel 0 is compared as a signed two's-complement value. Channels 1 to 4 are compared as unsigned values.
- R4: In `alarm_main_o`, channel c (0 to 3) has its high-alarm flag at bit 7-2c and its low-alarm flag at bit 6-2c. In `alarm_ext_o`, bit 7 is the channel 4 high alarm, bit 6 is the channel 4 low alarm, and bits 5:0 are always 0.
- R5: `warn_main_o` and `warn_ext_o` use the same bit layout as R4, but are compared against the warning limits.
- R6: A high flag is set only when the reading is strictly greater than its limit. A low flag is set only when the reading is strictly smaller than its limit. A reading equal to a limit sets no flag.
- R7: When the strobe is high at a clock edge, the flags computed from the inputs at that edge appear on the outputs after that edge. When the strobe is low, the outputs do not change, even if the readings or limits change.
- R8: Flags are not sticky. A flag that was set clears at the next strobe once its reading is back inside the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| sample_i | input | 1 | Strobe that starts a new comparison |
| reading_i | input | 80 | Five 16-bit readings. Channel c is at bits [16c+15:16c]. |
| limit_bytes_i | input | 320 | 40-byte limit region. Byte b is at bits [8b+7:8b]. |
| alarm_main_o | output | 8 | Alarm flags for channels 0 to 3 |
| alarm_ext_o | output | 8 | Alarm flags for channel 4 (bits 7:6). Bits 5:0 are zero. |
| warn_main_o | output | 8 | Warning flags for channels 0 to 3 |
| warn_ext_o | output | 8 | Warning flags for channel 4 (bits 7:6). Bits 5:0 are zero. |

## Verification
The assertions check these properties on every cycle:
- The reserved bits stay zero.
- The outputs do not move without a strobe.
- The flags are zero when reset is released.
- A reading equal to a limit never raises that limit's flag.
- High and low flags of one pair never fire together when the pair's limits are ordered.

Only the bench scenarios can show the rest: the exact bit each channel lands on, the signed treatment of temperature against an unsigned supply reading with its top bit set, the big-endian assembly of the limit words, and the clearing of a flag once its reading is back inside the limit.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int unsigned MLC_WORD_W   = 16;
  localparam int unsigned MLC_NUM_CH   = 5;
  localparam int unsigned MLC_LIM_PER  = 4;
  localparam int unsigned MLC_MAIN_CH  = 4;
  localparam int unsigned MLC_NUM_WORD = MLC_NUM_CH * MLC_LIM_PER;
  localparam int unsigned MLC_NUM_BYTE = MLC_NUM_WORD * 2;

  // Order of the four limit words inside one channel slot
  typedef enum logic [1:0] {
    LIM_HI_ALM = 2'd0,
    LIM_LO_ALM = 2'd1,
    LIM_HI_WRN = 2'd2,
    LIM_LO_WRN = 2'd3
  } lim_kind_e;

  typedef struct packed {
    logic hi_alm;
    logic lo_alm;
    logic hi_wrn;
    logic lo_wrn;
  } lim_flags_t;

  typedef struct packed {
    logic [7:0] alm_main;
    logic [7:0] alm_ext;
    logic [7:0] wrn_main;
    logic [7:0] wrn_ext;
  } flag_bytes_t;
endpackage

// File: rtl/mlc_chan_cmp.sv
module mlc_chan_cmp #(
  parameter int unsigned WORD_W     = 16,
  parameter bit          SIGNED_CMP = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [WORD_W-1:0]   value_i,
  input  logic [WORD_W-1:0]   hi_alm_i,
  input  logic [WORD_W-1:0]   lo_alm_i,
  input  logic [WORD_W-1:0]   hi_wrn_i,
  input  logic [WORD_W-1:0]   lo_wrn_i,
  output mlc_pkg::lim_flags_t flags_o
);
  logic alm_ordered;
  logic wrn_ordered;

  generate
    if (SIGNED_CMP) begin : g_signed
      always_comb begin
        flags_o.hi_alm = $signed(value_i) > $signed(hi_alm_i);
        flags_o.lo_alm = $signed(value_i) < $signed(lo_alm_i);
        flags_o.hi_wrn = $signed(value_i) > $signed(hi_wrn_i);
        flags_o.lo_wrn = $signed(value_i) < $signed(lo_wrn_i);
        alm_ordered    = $signed(hi_alm_i) >= $signed(lo_alm_i);
        wrn_ordered    = $signed(hi_wrn_i) >= $signed(lo_wrn_i);
      end
    end else begin : g_unsigned
      always_comb begin
        flags_o.hi_alm = value_i > hi_alm_i;
        flags_o.lo_alm = value_i < lo_alm_i;
        flags_o.hi_wrn = value_i > hi_wrn_i;
        flags_o.lo_wrn = value_i < lo_wrn_i;
        alm_ordered    = hi_alm_i >= lo_alm_i;
        wrn_ordered    = hi_wrn_i >= lo_wrn_i;
      end
    end
  endgenerate

  AST_EQ_HI_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (value_i == hi_alm_i) |-> !flags_o.hi_alm); // R6
  AST_EQ_LO_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (value_i == lo_wrn_i) |-> !flags_o.lo_wrn); // R6
  AST_ALM_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alm_ordered |-> !(flags_o.hi_alm && flags_o.lo_alm)); // R3
  AST_WRN_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrn_ordered |-> !(flags_o.hi_wrn && flags_o.lo_wrn)); // R3
endmodule

// File: rtl/mlc_flag_pack.sv
module mlc_flag_pack #(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned MAIN_CH = 4
) (
  input  mlc_pkg::lim_flags_t flags_i [NUM_CH],
  output mlc_pkg::flag_bytes_t bytes_o
);
  localparam int unsigned EXT_CH = NUM_CH - MAIN_CH;

  logic [7:0] alm_main;
  logic [7:0] alm_ext;
  logic [7:0] wrn_main;
  logic [7:0] wrn_ext;

  generate
    for (genvar c = 0; c < MAIN_CH; c++) begin : g_main
      assign alm_main[7-2*c] = flags_i[c].hi_alm;
      assign alm_main[6-2*c] = flags_i[c].lo_alm;
      assign wrn_main[7-2*c] = flags_i[c].hi_wrn;
      assign wrn_main[6-2*c] = flags_i[c].lo_wrn;
    end
    for (genvar e = 0; e < EXT_CH; e++) begin : g_ext
      assign alm_ext[7-2*e] = flags_i[MAIN_CH+e].hi_alm;
      assign alm_ext[6-2*e] = flags_i[MAIN_CH+e].lo_alm;
      assign wrn_ext[7-2*e] = flags_i[MAIN_CH+e].hi_wrn;
      assign wrn_ext[6-2*e] = flags_i[MAIN_CH+e].lo_wrn;
    end
    if (EXT_CH < 4) begin : g_rsvd
      assign alm_ext[7-2*EXT_CH:0] = '0;
      assign wrn_ext[7-2*EXT_CH:0] = '0;
    end
  endgenerate

  assign bytes_o = '{alm_main: alm_main, alm_ext: alm_ext,
                     wrn_main: wrn_main, wrn_ext: wrn_ext};
endmodule

// File: rtl/mon_limit_cmp.sv
module mon_limit_cmp
  import mlc_pkg::*;
#(
  parameter int unsigned WORD_W = MLC_WORD_W,
  parameter int unsigned NUM_CH = MLC_NUM_CH
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         sample_i,
  input  logic [NUM_CH*WORD_W-1:0]     reading_i,
  input  logic [NUM_CH*MLC_LIM_PER*WORD_W-1:0] limit_bytes_i,
  output logic [7:0]                   alarm_main_o,
  output logic [7:0]                   alarm_ext_o,
  output logic [7:0]                   warn_main_o,
  output logic [7:0]                   warn_ext_o
);
  localparam int unsigned BYTES_PER_WORD = WORD_W / 8;

  // Reset: asserted asynchronously, released through two flops
  logic rst_sync_q1, rst_sync_q2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q1 <= 1'b0;
      rst_sync_q2 <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_sync_q2 <= rst_sync_q1;
    end
  end

  lim_flags_t  ch_flags [NUM_CH];
  flag_bytes_t packed_d;
  flag_bytes_t flags_d;
  flag_bytes_t flags_q;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [WORD_W-1:0] lim_w [MLC_LIM_PER];
      for (genvar k = 0; k < MLC_LIM_PER; k++) begin : g_word
        localparam int unsigned WIDX = c * MLC_LIM_PER + k;
        // Lower byte address carries the most significant byte
        for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
          assign lim_w[k][WORD_W-1-8*b -: 8] =
            limit_bytes_i[8*(WIDX*BYTES_PER_WORD+b) +: 8];
        end
      end
      mlc_chan_cmp #(
        .WORD_W    (WORD_W),
        .SIGNED_CMP(c == 0)
      ) u_cmp (
        .clk_i   (clk_i),
        .rst_ni  (rst_sync_q2),
        .value_i (reading_i[c*WORD_W +: WORD_W]),
        .hi_alm_i(lim_w[LIM_HI_ALM]),
        .lo_alm_i(lim_w[LIM_LO_ALM]),
        .hi_wrn_i(lim_w[LIM_HI_WRN]),
        .lo_wrn_i(lim_w[LIM_LO_WRN]),
        .flags_o (ch_flags[c])
      );
    end
  endgenerate

  mlc_flag_pack #(
    .NUM_CH (NUM_CH),
    .MAIN_CH(MLC_MAIN_CH)
  ) u_pack (
    .flags_i(ch_flags),
    .bytes_o(packed_d)
  );

  always_comb begin
    flags_d = flags_q;
    if (sample_i) flags_d = packed_d;
  end

  always_ff @(posedge clk_i or negedge rst_sync_q2) begin
    if (!rst_sync_q2) flags_q <= '0;
    else              flags_q <= flags_d;
  end

  assign alarm_main_o = flags_q.alm_main;
  assign alarm_ext_o  = flags_q.alm_ext;
  assign warn_main_o  = flags_q.wrn_main;
  assign warn_ext_o   = flags_q.wrn_ext;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_sync_q2)
    (alarm_ext_o[5:0] == 6'd0) && (warn_ext_o[5:0] == 6'd0)); // R4
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_sync_q2)
    !sample_i |=> $stable({alarm_main_o, alarm_ext_o, warn_main_o, warn_ext_o})); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_sync_q2)
    $rose(rst_sync_q2) |-> ({alarm_main_o, alarm_ext_o, warn_main_o, warn_ext_o} == 32'd0)); // R1
endmodule

// File: tb/mon_limit_cmp_tb_top.sv
`timescale 1ns/1ps
module mon_limit_cmp_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         sample;
  logic [79:0]  reading;
  logic [319:0] lim_bytes;
  logic [7:0]   am, ae, wm, we;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  mon_limit_cmp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .reading_i(reading), .limit_bytes_i(lim_bytes),
    .alarm_main_o(am), .alarm_ext_o(ae), .warn_main_o(wm), .warn_ext_o(we)
  );

  // Limit words per channel: high alarm, low alarm, high warning, low warning
  localparam logic [15:0] LIMS [20] = '{
    16'h2000, 16'hF000, 16'h1000, 16'hF800,   // temperature (signed)
    16'h9000, 16'h6000, 16'h8800, 16'h6800,   // supply
    16'h4000, 16'h1000, 16'h3800, 16'h1800,   // bias
    16'h3000, 16'h0800, 16'h2800, 16'h0C00,   // tx power
    16'h5000, 16'h0400, 16'h4800, 16'h0600    // rx power
  };

  // {rx, tx, bias, supply, temp} readings, then {am, ae, wm, we}
  localparam logic [111:0] VEC [10] = '{
    {16'h2000, 16'h1800, 16'h2000, 16'h7800, 16'h0800, 32'h00_00_00_00},
    {16'h5100, 16'h3100, 16'h4100, 16'h9100, 16'h2100, 32'hAA_80_AA_80},
    {16'h0200, 16'h0400, 16'h0800, 16'h5000, 16'hE000, 32'h55_40_55_40},
    {16'h4C00, 16'h2C00, 16'h3C00, 16'h8C00, 16'h1800, 32'h00_00_AA_80},
    {16'h5000, 16'h3000, 16'h4000, 16'h9000, 16'h2000, 32'h00_00_AA_80},
    {16'h0400, 16'h0800, 16'h1000, 16'h6000, 16'hF000, 32'h00_00_55_40},
    {16'h4900, 16'h0000, 16'h2000, 16'h6400, 16'h7FFF, 32'h81_00_91_80},
    {16'h2000, 16'h1800, 16'h2000, 16'h7800, 16'hFFFF, 32'h00_00_00_00},
    {16'h2000, 16'h1800, 16'h2000, 16'hFFFF, 16'h8000, 32'h60_00_60_00},
    {16'h4800, 16'h0C00, 16'h3800, 16'h6800, 16'h1000, 32'h00_00_00_00}
  };
  localparam string VEC_REQ [10] = '{
    "R4 R5 nominal", "R4 R5 all high", "R3 R4 R5 all low", "R5 warn only",
    "R6 equal high alarm", "R6 equal low alarm", "R4 R5 mixed",
    "R3 temp minus one", "R3 signed min vs unsigned max", "R6 equal warn limits"
  };

  function automatic logic [319:0] pack_limits(input logic [15:0] w [20]);
    logic [319:0] r;
    for (int i = 0; i < 20; i++) begin
      r[16*i +: 8]     = w[i][15:8];
      r[16*i + 8 +: 8] = w[i][7:0];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    n_checks++;
    if ({am, ae, wm, we} !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, {am, ae, wm, we}, exp);
    end
  endtask

  task automatic strobe(input logic [79:0] rd);
    @(negedge clk);
    reading = rd;
    sample  = 1'b1;
    @(negedge clk);
    sample  = 1'b0;
  endtask

  initial begin
    #500000;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [15:0] lw [20];
    rst_n = 1'b0; sample = 1'b0;
    reading = VEC[1][111:32];
    lim_bytes = pack_limits(LIMS);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset without strobe", 32'h0);
    repeat (3) @(negedge clk);
    check("R1 still zero before first strobe", 32'h0);

    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][111:32]);
      check(VEC_REQ[i], VEC[i][31:0]);
    end

    // R7: hold between strobes while readings and limits move
    strobe(VEC[1][111:32]);
    check("R7 strobe applied", 32'hAA80AA80);
    reading = VEC[2][111:32];
    lim_bytes = '1;
    repeat (4) @(negedge clk);
    check("R7 hold without strobe", 32'hAA80AA80);
    lim_bytes = pack_limits(LIMS);

    // R8: flags clear once readings return inside limits
    strobe(VEC[0][111:32]);
    check("R8 flags cleared", 32'h0);

    // R2: big-endian word assembly. Temp high alarm 0x0201; swapped would be 0x0102
    lw = LIMS;
    lw[0] = 16'h0201;
    lim_bytes = pack_limits(lw);
    strobe({16'h2000, 16'h1800, 16'h2000, 16'h7800, 16'h0150});
    check("R2 byte order below limit", 32'h0);
    strobe({16'h2000, 16'h1800, 16'h2000, 16'h7800, 16'h0202});
    check("R2 byte order above limit", 32'h80000000);

    // R2: rx low warning slot (word 19) drives only warn_ext bit 6
    lw = LIMS;
    lw[19] = 16'h2100;
    lim_bytes = pack_limits(lw);
    strobe(VEC[0][111:32]);
    check("R2 R5 rx low warning slot", 32'h00000040);

    // R1: reset in mid-run clears flags
    lim_bytes = pack_limits(LIMS);
    strobe(VEC[1][111:32]);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 zero after release", 32'h0);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule